// File: doc/BRIEF.md
# One-Bit Boolean Control Processor Core

This block is the execution core of a tiny single-bit controller meant for relay-style industrial logic. Every clock it takes a 4-bit opcode and one data bit from outside. Its logic unit combines that bit with a one-bit accumulator, the result register, and writes the answer back. Store opcodes drive the accumulator, or its inverse, onto a data output together with a write strobe. Jump, return and two flag opcodes raise one-cycle pulses. External logic watches these pulses to run a program counter, a return stack or a loop restart.

The core holds no program counter, no address and no memory. It provides two ways to run code conditionally. A skip-if-zero opcode, and also the return opcode, arm a skip state that turns the next opcode into a fully silent no-op. An input-enable flag and an output-enable flag can mute reads or writes over a whole stretch of code. All state is captured on the falling clock edge, and a synchronous active-high reset clears it.

The sequencer has two states. RUN executes the presented opcode. SKIP discards it. RUN goes to SKIP on a return opcode, or on skip-if-zero while the accumulator is 0. SKIP always goes back to RUN after one cycle. RUN stays in RUN on any other opcode.

Top module: `bitctl_core`

## Requirements
- R1: A reset seen on a falling edge clears the result register, both enable flags, the skip state, every pulse output, the write strobe and the output drive enable.
- R2: With input enable at 1, the logic opcodes update the result register r from data bit d as follows. 1 loads d. 2 loads ~d. 3 gives r&d. 4 gives r&~d. 5 gives r|d. 6 gives r|~d. 7 gives ~(r^d).
- R3: While input enable is 0, the logic opcodes 1 to 7 use a data bit of 0 whatever the data input carries. For example, opcode 1 leaves r at 0 and opcode 2 sets it to 1.
- R4: Opcode A loads input enable from the data input, and opcode B loads output enable from the data input. The data input is taken raw here, not gated by input enable.
- R5: Opcode 8 drives r, and opcode 9 drives ~r, on the data output. When output enable is 1, write strobe and output drive enable are raised together for exactly one cycle. When output enable is 0, neither is raised. No store changes r.
- R6: Opcodes 0 (flag O), C (jump), D (return) and F (flag F) each raise their own pulse output for exactly one cycle. At most one of these pulses and the write strobe is high in any cycle.
- R7: Opcode E with r equal to 0 makes the next opcode have no effect at all: no pulse, no strobe and no change to r or the flags. With r equal to 1 it does nothing.
- R8: Opcode D, in addition to its pulse, makes the following opcode have no effect, in the same way as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode executed at the next falling edge |
| data_in | input | 1 | Data bit read by logic and enable opcodes |
| data_out | output | 1 | Value driven by the last store |
| data_oe | output | 1 | Output drive enable for the data line, one cycle per enabled store |
| write_strobe | output | 1 | One-cycle write pulse for an enabled store |
| jump_pulse | output | 1 | One-cycle pulse on jump |
| return_pulse | output | 1 | One-cycle pulse on return |
| flag_o_pulse | output | 1 | One-cycle pulse on flag-O no-op |
| flag_f_pulse | output | 1 | One-cycle pulse on flag-F no-op |
| result | output | 1 | Current result register |

## Verification
A corrupted accumulator shows on the result output in the cycle after the falling edge that wrote it, and it spreads into every later logic or store result. A wrong enable flag stays hidden until the next logic opcode gives a wrong result or the next store gives a wrong strobe. That can take many cycles, so the random stimulus mixes enable changes with logic and store opcodes. A skip state that is armed wrongly or left stuck shows one instruction later as a missing or extra pulse, or as a result that does not change when it should.

// File: rtl/bitctl_pkg.sv
package bitctl_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOPO = 4'h0, OP_LD   = 4'h1, OP_LDC  = 4'h2, OP_AND  = 4'h3,
        OP_ANDC = 4'h4, OP_OR   = 4'h5, OP_ORC  = 4'h6, OP_XNOR = 4'h7,
        OP_STO  = 4'h8, OP_STOC = 4'h9, OP_IEN  = 4'hA, OP_OEN  = 4'hB,
        OP_JMP  = 4'hC, OP_RTN  = 4'hD, OP_SKZ  = 4'hE, OP_NOPF = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        LU_LD, LU_LDC, LU_AND, LU_ANDC, LU_OR, LU_ORC, LU_XNOR, LU_NONE
    } lu_fn_e;

    typedef struct packed {
        logic   lu_wr;
        lu_fn_e fn;
        logic   sto;
        logic   inv;
        logic   set_ien;
        logic   set_oen;
        logic   jmp;
        logic   rtn;
        logic   skz;
        logic   nopo;
        logic   nopf;
    } ctl_t;

    typedef enum logic [0:0] {S_RUN, S_SKIP} seq_e;
endpackage

// File: rtl/bitctl_decode.sv
module bitctl_decode
    import bitctl_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output ctl_t            ctl
);
    always_comb begin
        ctl    = '0;
        ctl.fn = LU_NONE;
        case (op_e'(op))
            OP_NOPO: ctl.nopo = 1'b1;
            OP_LD:   begin ctl.lu_wr = 1'b1; ctl.fn = LU_LD;   end
            OP_LDC:  begin ctl.lu_wr = 1'b1; ctl.fn = LU_LDC;  end
            OP_AND:  begin ctl.lu_wr = 1'b1; ctl.fn = LU_AND;  end
            OP_ANDC: begin ctl.lu_wr = 1'b1; ctl.fn = LU_ANDC; end
            OP_OR:   begin ctl.lu_wr = 1'b1; ctl.fn = LU_OR;   end
            OP_ORC:  begin ctl.lu_wr = 1'b1; ctl.fn = LU_ORC;  end
            OP_XNOR: begin ctl.lu_wr = 1'b1; ctl.fn = LU_XNOR; end
            OP_STO:  ctl.sto = 1'b1;
            OP_STOC: begin ctl.sto = 1'b1; ctl.inv = 1'b1; end
            OP_IEN:  ctl.set_ien = 1'b1;
            OP_OEN:  ctl.set_oen = 1'b1;
            OP_JMP:  ctl.jmp = 1'b1;
            OP_RTN:  ctl.rtn = 1'b1;
            OP_SKZ:  ctl.skz = 1'b1;
            OP_NOPF: ctl.nopf = 1'b1;
            default: ctl.fn = LU_NONE;
        endcase
    end
endmodule

// File: rtl/bitctl_lu.sv
module bitctl_lu
    import bitctl_pkg::*;
(
    input  lu_fn_e fn,
    input  logic   d,
    input  logic   acc,
    output logic   res
);
    always_comb begin
        unique case (fn)
            LU_LD:   res = d;
            LU_LDC:  res = ~d;
            LU_AND:  res = acc & d;
            LU_ANDC: res = acc & ~d;
            LU_OR:   res = acc | d;
            LU_ORC:  res = acc | ~d;
            LU_XNOR: res = ~(acc ^ d);
            default: res = acc;
        endcase
    end
endmodule

// File: rtl/bitctl_core.sv
module bitctl_core
    import bitctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            data_in,
    output logic            data_out,
    output logic            data_oe,
    output logic            write_strobe,
    output logic            jump_pulse,
    output logic            return_pulse,
    output logic            flag_o_pulse,
    output logic            flag_f_pulse,
    output logic            result
);
    ctl_t ctl;
    seq_e state_q, state_d;
    logic rr_q, ien_q, oen_q, lu_res, d_eff;
    logic dout_q, wr_q, jmp_q, rtn_q, fo_q, ff_q;

    bitctl_decode dec_i (.op(opcode), .ctl(ctl));

    assign d_eff = ien_q & data_in;

    bitctl_lu lu_i (.fn(ctl.fn), .d(d_eff), .acc(rr_q), .res(lu_res));

    // next-state logic
    always_comb begin
        unique case (state_q)
            S_RUN:  state_d = (ctl.rtn || (ctl.skz && !rr_q)) ? S_SKIP : S_RUN;
            S_SKIP: state_d = S_RUN;
            default: state_d = S_RUN;
        endcase
    end

    // state register
    always_ff @(negedge clk) begin
        if (rst) state_q <= S_RUN;
        else     state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(negedge clk) begin
        if (rst) begin
            rr_q   <= 1'b0;
            ien_q  <= 1'b0;
            oen_q  <= 1'b0;
            dout_q <= 1'b0;
            wr_q   <= 1'b0;
            jmp_q  <= 1'b0;
            rtn_q  <= 1'b0;
            fo_q   <= 1'b0;
            ff_q   <= 1'b0;
        end else begin
            wr_q  <= 1'b0;
            jmp_q <= 1'b0;
            rtn_q <= 1'b0;
            fo_q  <= 1'b0;
            ff_q  <= 1'b0;
            unique case (state_q)
                S_RUN: begin
                    if (ctl.lu_wr)   rr_q  <= lu_res;
                    if (ctl.set_ien) ien_q <= data_in;
                    if (ctl.set_oen) oen_q <= data_in;
                    if (ctl.sto) begin
                        wr_q   <= oen_q;
                        dout_q <= rr_q ^ ctl.inv;
                    end
                    jmp_q <= ctl.jmp;
                    rtn_q <= ctl.rtn;
                    fo_q  <= ctl.nopo;
                    ff_q  <= ctl.nopf;
                end
                S_SKIP: ;
                default: ;
            endcase
        end
    end

    assign data_out     = dout_q;
    assign data_oe      = wr_q;
    assign write_strobe = wr_q;
    assign jump_pulse   = jmp_q;
    assign return_pulse = rtn_q;
    assign flag_o_pulse = fo_q;
    assign flag_f_pulse = ff_q;
    assign result       = rr_q;
endmodule

// File: rtl/bitctl_core_chk.sv
module bitctl_core_chk
    import bitctl_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] opcode,
    input logic            rr,
    input logic            ien,
    input logic            oen,
    input seq_e            state,
    input logic            wr,
    input logic            jmp,
    input logic            rtn,
    input logic            fo,
    input logic            ff
);
    AST_PULSE_ONEHOT: assert property (@(negedge clk) disable iff (rst)
        $onehot0({jmp, rtn, fo, ff, wr})); // R6

    AST_SKIP_SILENT: assert property (@(negedge clk) disable iff (rst)
        (state == S_SKIP) |=> (!jmp && !rtn && !fo && !ff && !wr && $stable(rr))); // R7

    AST_SKZ_ARMS: assert property (@(negedge clk) disable iff (rst)
        (state == S_RUN && opcode == OP_SKZ && !rr) |=> (state == S_SKIP)); // R7

    AST_RTN_ARMS: assert property (@(negedge clk) disable iff (rst)
        (state == S_RUN && opcode == OP_RTN) |=> (rtn && state == S_SKIP)); // R8

    AST_STORE_MUTED: assert property (@(negedge clk) disable iff (rst)
        (state == S_RUN && (opcode == OP_STO || opcode == OP_STOC) && !oen) |=> !wr); // R5

    AST_INPUT_MUTED: assert property (@(negedge clk) disable iff (rst)
        (state == S_RUN && opcode == OP_LD && !ien) |=> !rr); // R3
endmodule

bind bitctl_core bitctl_core_chk chk_i (
    .clk(clk), .rst(rst), .opcode(opcode), .rr(rr_q), .ien(ien_q), .oen(oen_q),
    .state(state_q), .wr(wr_q), .jmp(jmp_q), .rtn(rtn_q), .fo(fo_q), .ff(ff_q)
);

// File: tb/bitctl_core_tb_top.sv
module bitctl_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = 4'h0;
    logic       data_in = 1'b0;
    logic data_out, data_oe, write_strobe, jump_pulse, return_pulse;
    logic flag_o_pulse, flag_f_pulse, result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic m_rr = 1'b0, m_ien = 1'b0, m_oen = 1'b0, m_skip = 1'b0, m_skip_rtn = 1'b0;

    always #10 clk = ~clk;

    bitctl_core dut_i (
        .clk(clk), .rst(rst), .opcode(opcode), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .write_strobe(write_strobe),
        .jump_pulse(jump_pulse), .return_pulse(return_pulse),
        .flag_o_pulse(flag_o_pulse), .flag_f_pulse(flag_f_pulse), .result(result)
    );

    function automatic logic lu_ref(input logic [3:0] op, input logic r, input logic d);
        case (op)
            4'h1: return d;
            4'h2: return ~d;
            4'h3: return r & d;
            4'h4: return r & ~d;
            4'h5: return r | d;
            4'h6: return r | ~d;
            4'h7: return ~(r ^ d);
            default: return r;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic skip,
                                     input logic skip_rtn, input logic ien);
        if (skip) return skip_rtn ? "R8" : "R7";
        case (op)
            4'h0, 4'hC, 4'hF: return "R6";
            4'hD: return "R8";
            4'h8, 4'h9: return "R5";
            4'hA, 4'hB: return "R4";
            4'hE: return "R7";
            default: return ien ? "R2" : "R3";
        endcase
    endfunction

    function automatic logic [7:0] sample_outs();
        return {result, jump_pulse, return_pulse, flag_o_pulse, flag_f_pulse,
                write_strobe, data_oe, data_oe ? data_out : 1'b0};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: outputs {rr,jmp,rtn,fo,ff,ws,oe,dout} actual %b expected %b",
                     req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic d);
        logic [7:0] exp;
        logic ws, dv, nrr;
        string req;
        req = req_of(op, m_skip, m_skip_rtn, m_ien);
        opcode  = op;
        data_in = d;
        if (m_skip) begin
            exp = {m_rr, 7'b0};
            m_skip = 1'b0;
        end else begin
            nrr = (op >= 4'h1 && op <= 4'h7) ? lu_ref(op, m_rr, m_ien & d) : m_rr;
            ws  = (op == 4'h8 || op == 4'h9) && m_oen;
            dv  = ws ? (m_rr ^ (op == 4'h9)) : 1'b0;
            exp = {nrr, op == 4'hC, op == 4'hD, op == 4'h0, op == 4'hF, ws, ws, dv};
            if (op == 4'hA) m_ien = d;
            if (op == 4'hB) m_oen = d;
            m_skip     = (op == 4'hD) || (op == 4'hE && !m_rr);
            m_skip_rtn = (op == 4'hD);
            m_rr = nrr;
        end
        @(posedge clk);
        #1;
        check(req, sample_outs(), exp);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1", sample_outs(), 8'b0);           // R1 reset state
        step(4'h1, 1'b1);                           // R3: LD with input disabled -> 0
        step(4'h2, 1'b1);                           // R3: LDC sees 0 -> 1
        step(4'h8, 1'b0);                           // R5: store with output disabled
        step(4'hA, 1'b1);                           // R4
        step(4'hB, 1'b1);                           // R4
        step(4'h1, 1'b0);                           // R2
        step(4'h5, 1'b1);                           // R2
        step(4'h8, 1'b0);                           // R5 store r
        step(4'h9, 1'b0);                           // R5 store ~r
        step(4'hE, 1'b0);                           // R7 r=1: no skip
        step(4'hC, 1'b0);                           // R6 jump runs
        step(4'h1, 1'b0);
        step(4'hE, 1'b0);                           // R7 r=0: arm skip
        step(4'h0, 1'b0);                           // R7 flag-O suppressed
        step(4'hE, 1'b0);
        step(4'h2, 1'b1);                           // R7 load suppressed
        step(4'hD, 1'b0);                           // R8 return pulse
        step(4'hC, 1'b0);                           // R8 jump suppressed
        step(4'hF, 1'b0);                           // R6
        step(4'h0, 1'b0);                           // R6
        step(4'hB, 1'b0);                           // R4 output off
        step(4'h9, 1'b0);                           // R5 no strobe
        step(4'hA, 1'b0);                           // R4 input off
        step(4'h7, 1'b1);                           // R3 xnor with 0
        step(4'hA, 1'b1);
        step(4'hB, 1'b1);
        void'($urandom(32'd20240611));
        for (int i = 0; i < 600; i++) begin
            logic [3:0] op;
            logic d;
            op = 4'($urandom_range(15, 0));
            d  = 1'($urandom_range(1, 0));
            if (op == 4'hA || op == 4'hB) d = ($urandom_range(3, 0) != 0);
            step(op, d);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule